// File: doc/BRIEF.md
# System Counter with Per-Processor Timer Mode Control

This block is the system-level counter of a multiprocessor timer group. It holds one free-running counter that always works in limit mode: a prescaler turns the core clock into count steps, the counter climbs from zero to a programmable limit and wraps, and each wrap raises a sticky flag and the system interrupt. Software clears that interrupt by reading the limit word back.

Next to the counter sits a mode register with one bit per processor timer, up to sixteen of them. A bit set to 1 puts the matching processor timer in user mode; 0 leaves it in limit mode. One write to the mode word fans out into per-processor strobes. Each bit written as 1 gets a one-cycle interrupt-clear strobe. Each bit whose value changes gets a one-cycle restart strobe, so that processor timer reloads from zero under its new mode. The processor timers themselves sit outside this block and sample the mode bit and the strobes on the same clock edge.

The register port is word addressed, with five words. The counter value shows in bits 30 down to `CNT_LSB`, and the bits below stay zero. Read data is registered and appears one cycle after the read strobe.

Top module: `sysctr_top`

## Requirements
- R1: After reset the limit is the maximum value (word 0 reads 0x7FFFFE00 with the default `CNT_LSB` of 9), the count is zero, `sys_irq` is low, the mode register and all per-processor outputs are zero, and `reg_rdata` is zero.
- R2: A write to word 0 loads the limit from `reg_wdata[30:CNT_LSB]`, and a zero field loads the maximum instead. The same write also sets the count and the prescaler to zero and clears the reached flag and `sys_irq`.
- R3: A write to word 2 loads the limit under the same zero-means-maximum rule, without disturbing the count, the prescaler or the reached flag.
- R4: The count advances by one every `TICK_DIV` cycles. On the step where count+1 is at least the limit, the count returns to zero, and the reached flag and `sys_irq` are set on that same edge. With `TICK_DIV`=4 and a limit of 3 written at edge E, `sys_irq` rises at edge E+12.
- R5: Reading word 0 returns the limit in bits 30:CNT_LSB with every other bit zero, and clears the reached flag and `sys_irq`.
- R6: Reading word 1 returns the reached flag in bit 31 and the count in bits 30:CNT_LSB, with the low bits zero, and clears nothing.
- R7: A write to word 4 stores `reg_wdata[NPROC-1:0]` as the mode bits (bit i = 1 means user mode for processor i) and ignores higher bits. `cpu_user_mode` shows the stored bits from the edge after the write, and reading word 4 returns them zero-extended.
- R8: A write to word 4 drives `cpu_irq_clr[i]` high for exactly one cycle, starting at the write edge, for every bit i written as 1, whether or not the bit changed.
- R9: A write to word 4 drives `cpu_restart[i]` high for exactly one cycle, for every bit i whose written value differs from the stored one, in the same cycle as the new `cpu_user_mode` value.
- R10: Word 3 and addresses 5 to 7 read as zero, and writes to them change neither the limit, the mode bits nor any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered, valid the cycle after `reg_rd` |
| sys_irq | output | 1 | System counter interrupt |
| cpu_user_mode | output | NPROC | Per-processor mode, 1 = user mode |
| cpu_irq_clr | output | NPROC | One-cycle interrupt-clear strobe per processor |
| cpu_restart | output | NPROC | One-cycle restart strobe per processor |

## Verification
The hardest case to reach from the ports is a mode write that sets some bits, clears others and rewrites others unchanged, all in one access. Only such a write shows that the clear and restart strobes follow different rules. A table of successive mode words is built so that each entry depends on the one before: rewrites of a set bit, a set and a clear in the same word, a full set, and a word with junk in its upper half. Each entry is checked on its strobe cycle, on the cycle after, and by a read-back. The wrap of the counter is timed to the exact edge by using a short prescaler and a tiny limit. Limit reloads during a count, both with and without a count reset, are timed the same way.

// File: rtl/sysctr_pkg.sv
package sysctr_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_LIMIT_RST  = 3'd0;
  localparam logic [ADDR_W-1:0] A_COUNT      = 3'd1;
  localparam logic [ADDR_W-1:0] A_LIMIT_KEEP = 3'd2;
  localparam logic [ADDR_W-1:0] A_MODE       = 3'd4;

  typedef struct packed {
    logic wr_limit_rst;
    logic wr_limit_keep;
    logic wr_mode;
    logic rd_limit;
  } reg_ops_t;
endpackage

// File: rtl/sysctr_tick.sv
module sysctr_tick #(
  parameter int unsigned DIV = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int unsigned PRE_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(DIV - 1);

  logic [PRE_W-1:0] pre_q;

  assign tick = (pre_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pre_q <= '0;
    end else if (tick) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  generate
    if (DIV > 1) begin : g_spacing
      p_tick_spacing_r4: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/sysctr_limit.sv
module sysctr_limit #(
  parameter int unsigned CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             ld_limit,
  input  logic [CNT_W-1:0] ld_value,
  input  logic             zero_count,
  input  logic             clr_hit,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] limit,
  output logic             hit,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] MAX_LIM = '1;

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] limit_q;
  logic             hit_q;
  logic [CNT_W:0]   next_cnt;

  assign next_cnt = {1'b0, count_q} + 1'b1;
  assign wrap     = tick && !zero_count && (next_cnt >= {1'b0, limit_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      limit_q <= MAX_LIM;
      count_q <= '0;
      hit_q   <= 1'b0;
    end else begin
      if (ld_limit) begin
        limit_q <= (ld_value == '0) ? MAX_LIM : ld_value;
      end
      if (zero_count) begin
        count_q <= '0;
      end else if (tick) begin
        count_q <= wrap ? '0 : next_cnt[CNT_W-1:0];
      end
      if (wrap) begin
        hit_q <= 1'b1;
      end else if (clr_hit) begin
        hit_q <= 1'b0;
      end
    end
  end

  assign count = count_q;
  assign limit = limit_q;
  assign hit   = hit_q;

  p_limit_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
    limit_q != '0);
  p_count_cleared_r2: assert property (@(posedge clk) disable iff (rst)
    zero_count |=> count_q == '0);
  p_wrap_sets_hit_r4: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (hit_q && count_q == '0));
  p_count_step_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && !zero_count && !wrap) |=> count_q == $past(count_q) + 1'b1);
  p_count_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!tick && !zero_count) |=> $stable(count_q));
endmodule

// File: rtl/sysctr_modefan.sv
module sysctr_modefan #(
  parameter int unsigned NPROC = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [NPROC-1:0] wbits,
  output logic [NPROC-1:0] mode,
  output logic [NPROC-1:0] irq_clr,
  output logic [NPROC-1:0] restart
);
  logic [NPROC-1:0] mode_q;
  logic [NPROC-1:0] clr_q;
  logic [NPROC-1:0] rst_q;

  generate
    for (genvar i = 0; i < NPROC; i++) begin : g_cpu
      always_ff @(posedge clk) begin
        if (rst) begin
          mode_q[i] <= 1'b0;
          clr_q[i]  <= 1'b0;
          rst_q[i]  <= 1'b0;
        end else begin
          clr_q[i] <= wr && wbits[i];
          rst_q[i] <= wr && (wbits[i] != mode_q[i]);
          if (wr) begin
            mode_q[i] <= wbits[i];
          end
        end
      end
    end
  endgenerate

  assign mode    = mode_q;
  assign irq_clr = clr_q;
  assign restart = rst_q;

  p_clr_only_user_r8: assert property (@(posedge clk) disable iff (rst)
    (clr_q & ~mode_q) == '0);
  p_restart_is_change_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> rst_q == (mode_q ^ $past(mode_q)));
  p_mode_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(mode_q));
  p_pulses_need_write_r8: assert property (@(posedge clk) disable iff (rst)
    !wr |=> (clr_q == '0 && rst_q == '0));
endmodule

// File: rtl/sysctr_top.sv
module sysctr_top #(
  parameter int unsigned NPROC    = 16,
  parameter int unsigned TICK_DIV = 100,
  parameter int unsigned CNT_LSB  = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             sys_irq,
  output logic [NPROC-1:0] cpu_user_mode,
  output logic [NPROC-1:0] cpu_irq_clr,
  output logic [NPROC-1:0] cpu_restart
);
  import sysctr_pkg::*;

  localparam int unsigned CNT_W = 31 - CNT_LSB;

  reg_ops_t         ops;
  logic             tick;
  logic             wrap;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] limit;
  logic             hit;
  logic [31:0]      rd_mux;
  logic [31:0]      rdata_q;
  logic             unused_wdata;

  assign unused_wdata = ^{reg_wdata[31], reg_wdata[CNT_LSB-1:0]};

  always_comb begin
    ops               = '0;
    ops.wr_limit_rst  = reg_wr && (reg_addr == A_LIMIT_RST);
    ops.wr_limit_keep = reg_wr && (reg_addr == A_LIMIT_KEEP);
    ops.wr_mode       = reg_wr && (reg_addr == A_MODE);
    ops.rd_limit      = reg_rd && (reg_addr == A_LIMIT_RST);
  end

  sysctr_tick #(.DIV(TICK_DIV)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .restart (ops.wr_limit_rst),
    .tick    (tick)
  );

  sysctr_limit #(.CNT_W(CNT_W)) u_limit (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .ld_limit   (ops.wr_limit_rst || ops.wr_limit_keep),
    .ld_value   (reg_wdata[30:CNT_LSB]),
    .zero_count (ops.wr_limit_rst),
    .clr_hit    (ops.wr_limit_rst || ops.rd_limit),
    .count      (count),
    .limit      (limit),
    .hit        (hit),
    .wrap       (wrap)
  );

  sysctr_modefan #(.NPROC(NPROC)) u_mode (
    .clk     (clk),
    .rst     (rst),
    .wr      (ops.wr_mode),
    .wbits   (reg_wdata[NPROC-1:0]),
    .mode    (cpu_user_mode),
    .irq_clr (cpu_irq_clr),
    .restart (cpu_restart)
  );

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_LIMIT_RST: rd_mux = {1'b0, limit, {CNT_LSB{1'b0}}};
      A_COUNT:     rd_mux = {hit, count, {CNT_LSB{1'b0}}};
      A_MODE:      rd_mux = {{(32-NPROC){1'b0}}, cpu_user_mode};
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (reg_rd) begin
      rdata_q <= rd_mux;
    end
  end

  assign reg_rdata = rdata_q;
  assign sys_irq   = hit;

  initial begin
    a_nproc_fits_r7: assert (NPROC >= 1 && NPROC <= 16);
  end

  p_read_clears_irq_r5: assert property (@(posedge clk) disable iff (rst)
    (ops.rd_limit && !wrap) |=> !sys_irq);
  p_unused_reads_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && (reg_addr == 3'd3 || reg_addr > 3'd4)) |=> reg_rdata == '0);
  p_limit_read_shape_r5: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == A_LIMIT_RST) |=>
      (reg_rdata[31] == 1'b0 && reg_rdata[CNT_LSB-1:0] == '0));
  p_irq_rises_on_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_irq) |-> $past(wrap));
endmodule

// File: tb/sim_sysctr_top.sv
`timescale 1ns/1ps
module sim_sysctr_top;
  localparam int unsigned NPROC = 16;
  localparam int unsigned TDIV  = 4;
  localparam int unsigned NVEC  = 7;

  // fields: [79:48] write data, [47:32] mode, [31:16] clear strobes, [15:0] restart strobes
  localparam logic [79:0] VEC [NVEC] = '{
    {32'h0000_0001, 16'h0001, 16'h0001, 16'h0001},
    {32'h0000_0001, 16'h0001, 16'h0001, 16'h0000},
    {32'h0000_8003, 16'h8003, 16'h8003, 16'h8002},
    {32'h0000_0000, 16'h0000, 16'h0000, 16'h8003},
    {32'h0000_FFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF},
    {32'hA5A5_0F0F, 16'h0F0F, 16'h0F0F, 16'hF0F0},
    {32'h0000_0F0F, 16'h0F0F, 16'h0F0F, 16'h0000}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             reg_wr = 1'b0;
  logic             reg_rd = 1'b0;
  logic [2:0]       reg_addr = '0;
  logic [31:0]      reg_wdata = '0;
  logic [31:0]      reg_rdata;
  logic             sys_irq;
  logic [NPROC-1:0] cpu_user_mode;
  logic [NPROC-1:0] cpu_irq_clr;
  logic [NPROC-1:0] cpu_restart;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  sysctr_top #(.NPROC(NPROC), .TICK_DIV(TDIV), .CNT_LSB(9)) u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sys_irq(sys_irq),
    .cpu_user_mode(cpu_user_mode), .cpu_irq_clr(cpu_irq_clr), .cpu_restart(cpu_restart)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 rdata", reg_rdata, 32'h0);
    check("R1 irq", {31'h0, sys_irq}, 32'h0);
    check("R1 mode", {16'h0, cpu_user_mode}, 32'h0);
    check("R1 strobes", {cpu_irq_clr, cpu_restart}, 32'h0);
    rd(3'd0, d); check("R1 limit max", d, 32'h7FFF_FE00);
    rd(3'd4, d); check("R1 mode word", d, 32'h0);

    // R7 R8 R9 mode table
    for (int i = 0; i < NVEC; i++) begin
      wr(3'd4, VEC[i][79:48]);
      check("R7 mode out", {16'h0, cpu_user_mode}, {16'h0, VEC[i][47:32]});
      check("R8 clr strobe", {16'h0, cpu_irq_clr}, {16'h0, VEC[i][31:16]});
      check("R9 restart strobe", {16'h0, cpu_restart}, {16'h0, VEC[i][15:0]});
      @(negedge clk);
      check("R8 clr one cycle", {16'h0, cpu_irq_clr}, 32'h0);
      check("R9 restart one cycle", {16'h0, cpu_restart}, 32'h0);
      rd(3'd4, d);
      check("R7 mode readback", d, {16'h0, VEC[i][47:32]});
    end

    // R2 R4 R6 R5 counter wrap timing, limit 3
    wr(3'd0, 32'h0000_0600);
    repeat (5) @(negedge clk);
    rd(3'd1, d); check("R6 count mid", d, 32'h0000_0200);
    repeat (5) @(negedge clk);
    check("R4 irq before wrap", {31'h0, sys_irq}, 32'h0);
    @(negedge clk);
    check("R4 irq at wrap", {31'h0, sys_irq}, 32'h1);
    rd(3'd1, d); check("R6 reached bit", d, 32'h8000_0000);
    check("R6 read keeps irq", {31'h0, sys_irq}, 32'h1);
    rd(3'd0, d); check("R5 limit read", d, 32'h0000_0600);
    check("R5 read clears irq", {31'h0, sys_irq}, 32'h0);
    rd(3'd1, d); check("R5 reached cleared", d, 32'h0);

    // R3 limit reload keeps count; R2 reload resets it
    wr(3'd0, 32'h0000_0A00);
    repeat (9) @(negedge clk);
    wr(3'd2, 32'h0000_0E00);
    rd(3'd1, d); check("R3 count kept", d, 32'h0000_0400);
    rd(3'd0, d); check("R3 limit loaded", d, 32'h0000_0E00);
    wr(3'd0, 32'h0000_0E00);
    rd(3'd1, d); check("R2 count reset", d, 32'h0);
    wr(3'd2, 32'h0);
    rd(3'd0, d); check("R3 zero gives max", d, 32'h7FFF_FE00);
    wr(3'd0, 32'h8000_01FF);
    rd(3'd0, d); check("R2 zero gives max", d, 32'h7FFF_FE00);

    // R10 unused words
    wr(3'd0, 32'h0000_1000);
    wr(3'd3, 32'hFFFF_FFFF);
    check("R10 no strobe w3", {cpu_irq_clr, cpu_restart}, 32'h0);
    wr(3'd5, 32'hFFFF_FFFF);
    check("R10 no strobe w5", {cpu_irq_clr, cpu_restart}, 32'h0);
    wr(3'd7, 32'h0000_0000);
    check("R10 mode kept", {16'h0, cpu_user_mode}, 32'h0000_0F0F);
    rd(3'd0, d); check("R10 limit kept", d, 32'h0000_1000);
    rd(3'd3, d); check("R10 read w3", d, 32'h0);
    rd(3'd5, d); check("R10 read w5", d, 32'h0);
    rd(3'd7, d); check("R10 read w7", d, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule